// File: doc/BRIEF.md
# Banked UART Register File

This block is the byte-wide register front end of a 16550-class serial controller. A host presents a 3-bit offset with a read or a write strobe; the block decodes the offset, holds the configuration registers that belong to it (interrupt enable, line control, modem control, scratch and the 16-bit baud divisor), and routes everything else to the neighbouring transmit, receive, FIFO and interrupt blocks through plain data ports and one-cycle strobes.

Offsets 0 and 1 are banked. Bit 7 of the line control register selects the bank. When that bit is clear, offset 0 is the data port and offset 1 is the interrupt enable register. When it is set, offsets 0 and 1 reach the low and high bytes of the divisor. Offset 2 is asymmetric: a read returns the interrupt identification byte and a write goes to FIFO control.

The stored divisor also drives a tick generator. `tick16` is the 16x oversampling enable. It is a one-cycle pulse once every divisor clock cycles. `bit_tick` marks every sixteenth such pulse, so the bit rate is the clock divided by 16 and then by the divisor. For example, a 1.8432 MHz clock with divisor 12 gives 9600 bit/s.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the line control, modem control, interrupt enable and scratch registers read 00h and the divisor reads 0001h.
- R2: With line control bit 7 clear, a write at offset 0 pulses `thr_wr` for that cycle with `thr_data` equal to the written byte. A read at offset 0 returns `rbr_data` and pulses `rbr_rd`.
- R3: With line control bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Neither `thr_wr` nor `rbr_rd` fires at offset 0 in this bank.
- R4: With line control bit 7 clear, offset 1 reaches the interrupt enable register. Only bits 3:0 are stored: bit 0 received data, bit 1 transmit empty, bit 2 line status, bit 3 modem status. Bits 7:4 read 0. A write to offset 1 while bit 7 is set leaves this register unchanged.
- R5: Offset 3 is the line control register, a fully readable and writable byte. Its bit 7 is the bank select for offsets 0 and 1 from the next cycle on.
- R6: At offset 2, a read returns `iir_data` and pulses `iir_rd`. A write pulses `fcr_wr` with `fcr_data` equal to the written byte and changes no stored register.
- R7: Offset 4 is the readable and writable modem control byte and offset 7 is the readable and writable scratch byte. Offsets 5 and 6 return `lsr_data` and `msr_data` with `lsr_rd` and `msr_rd` pulses. Writes to offsets 5 and 6 have no effect.
- R8: `tick16` is high for exactly one cycle in every N cycles, where N is the divisor. After reset (N = 1) it is high on every cycle.
- R9: A divisor of 0000h behaves as 0001h, so `tick16` stays high on every cycle.
- R10: `bit_tick` is high for one cycle on every 16th `tick16` pulse, coincident with it, giving a period of 16·N cycles.
- R11: With neither strobe asserted, no neighbour strobe fires and `rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 00h when not reading |
| thr_wr | output | 1 | Transmit byte load strobe |
| thr_data | output | 8 | Transmit byte |
| rbr_data | input | 8 | Received byte from the receiver |
| rbr_rd | output | 1 | Received byte consumed |
| iir_data | input | 8 | Interrupt identification byte |
| iir_rd | output | 1 | Interrupt identification read |
| fcr_wr | output | 1 | FIFO control write strobe |
| fcr_data | output | 8 | FIFO control byte |
| lsr_data | input | 8 | Line status byte |
| lsr_rd | output | 1 | Line status read |
| msr_data | input | 8 | Modem status byte |
| msr_rd | output | 1 | Modem status read |
| ier | output | 8 | Interrupt enable register |
| lcr | output | 8 | Line control register |
| mcr | output | 8 | Modem control register |
| divisor | output | 16 | Baud divisor |
| tick16 | output | 1 | 16x oversampling enable |
| bit_tick | output | 1 | One-per-bit enable |

## Verification
On every cycle, the assertions check the following. The bank bit blocks the data-port strobes. Divisor and line control writes land on the next cycle. The interrupt enable register holds unless it is addressed. Idle cycles stay silent. A zero divisor keeps the tick running. Neither tick repeats on consecutive cycles while the divisor is above one. The exact pulse periods (N and 16·N), the read-back values through both banks, and the fact that writes to status offsets are ignored can only be shown by the bench's scenarios, which measure gaps between pulses and read registers back through the bus.

// File: rtl/uart_rb_pkg.sv
`timescale 1ns/1ps
// Package: shared target encoding and offset decode for the UART register file.
// Assumes a 3-bit offset and a single bank bit taken from line control bit 7.
package uart_rb_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;
    localparam int BANK_BIT = 7;

    typedef enum logic [3:0] {
        TGT_TXRX   = 4'd0,
        TGT_DLO    = 4'd1,
        TGT_IEN    = 4'd2,
        TGT_DHI    = 4'd3,
        TGT_IDFC   = 4'd4,
        TGT_LCTL   = 4'd5,
        TGT_MCTL   = 4'd6,
        TGT_LSTAT  = 4'd7,
        TGT_MSTAT  = 4'd8,
        TGT_SCRAT  = 4'd9
    } tgt_e;

    // Map an offset and the bank bit onto the addressed register.
    function automatic tgt_e pick_target(input logic [2:0] off, input logic bank);
        case (off)
            3'd0:    return bank ? TGT_DLO : TGT_TXRX;
            3'd1:    return bank ? TGT_DHI : TGT_IEN;
            3'd2:    return TGT_IDFC;
            3'd3:    return TGT_LCTL;
            3'd4:    return TGT_MCTL;
            3'd5:    return TGT_LSTAT;
            3'd6:    return TGT_MSTAT;
            default: return TGT_SCRAT;
        endcase
    endfunction

endpackage

// File: rtl/uart_rb_decode.sv
`timescale 1ns/1ps
// Module: uart_rb_decode
// Turns offset, bank bit and the two bus strobes into a target code and
// one-cycle per-register strobes. Purely combinational; assumes at most one
// offset is presented per cycle. Writes to the status offsets are not decoded.
module uart_rb_decode
    import uart_rb_pkg::*;
(
    input  logic [2:0] addr,
    input  logic       bank,
    input  logic       wr_en,
    input  logic       rd_en,
    output tgt_e       tgt,
    output logic       wr_txd,
    output logic       wr_dlo,
    output logic       wr_dhi,
    output logic       wr_ien,
    output logic       wr_fctl,
    output logic       wr_lctl,
    output logic       wr_mctl,
    output logic       wr_scrat,
    output logic       rd_rxd,
    output logic       rd_iid,
    output logic       rd_lstat,
    output logic       rd_mstat
);

    // Resolve the addressed register from the offset and bank.
    always_comb begin
        tgt = pick_target(addr, bank);
    end

    // Qualify the target with the write strobe.
    always_comb begin
        wr_txd   = wr_en && (tgt == TGT_TXRX);
        wr_dlo   = wr_en && (tgt == TGT_DLO);
        wr_dhi   = wr_en && (tgt == TGT_DHI);
        wr_ien   = wr_en && (tgt == TGT_IEN);
        wr_fctl  = wr_en && (tgt == TGT_IDFC);
        wr_lctl  = wr_en && (tgt == TGT_LCTL);
        wr_mctl  = wr_en && (tgt == TGT_MCTL);
        wr_scrat = wr_en && (tgt == TGT_SCRAT);
    end

    // Qualify the target with the read strobe for side-effect reads.
    always_comb begin
        rd_rxd   = rd_en && (tgt == TGT_TXRX);
        rd_iid   = rd_en && (tgt == TGT_IDFC);
        rd_lstat = rd_en && (tgt == TGT_LSTAT);
        rd_mstat = rd_en && (tgt == TGT_MSTAT);
    end

endmodule

// File: rtl/uart_rb_regs.sv
`timescale 1ns/1ps
// Module: uart_rb_regs
// Storage for the configuration registers owned by the register file:
// interrupt enable (low IER_BITS only), line control, modem control, scratch
// and the two divisor bytes. Assumes one-hot write strobes from the decoder.
module uart_rb_regs
    import uart_rb_pkg::*;
#(
    parameter int IER_BITS  = 4,
    parameter int RESET_DIV = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                wr_dlo,
    input  logic                wr_dhi,
    input  logic                wr_ien,
    input  logic                wr_lctl,
    input  logic                wr_mctl,
    input  logic                wr_scrat,
    output logic [IER_BITS-1:0] ien_q,
    output logic [BYTE_W-1:0]   lctl_q,
    output logic [BYTE_W-1:0]   mctl_q,
    output logic [BYTE_W-1:0]   scrat_q,
    output logic [DIV_W-1:0]    div_q,
    output logic                div_load
);

    // Interrupt enable: keep only the implemented low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= wdata[IER_BITS-1:0];
    end

    // Line control: full byte, bit BANK_BIT selects the divisor bank.
    always_ff @(posedge clk) begin
        if (!rst_n)       lctl_q <= '0;
        else if (wr_lctl) lctl_q <= wdata;
    end

    // Modem control: full byte handed to the modem-line logic.
    always_ff @(posedge clk) begin
        if (!rst_n)       mctl_q <= '0;
        else if (wr_mctl) mctl_q <= wdata;
    end

    // Scratch: general-purpose byte with no side effect.
    always_ff @(posedge clk) begin
        if (!rst_n)        scrat_q <= '0;
        else if (wr_scrat) scrat_q <= wdata;
    end

    // Divisor: two independently written bytes, reset to RESET_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(RESET_DIV);
        end else begin
            if (wr_dlo) div_q[BYTE_W-1:0]     <= wdata;
            if (wr_dhi) div_q[DIV_W-1:BYTE_W] <= wdata;
        end
    end

    // Any divisor byte write restarts the tick counters.
    always_comb begin
        div_load = wr_dlo || wr_dhi;
    end

    AST_DLO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dlo |=> (div_q[BYTE_W-1:0] == $past(wdata)));             // R3
    AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ien |=> $stable(ien_q));                                 // R4
    AST_LCTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lctl |=> (lctl_q == $past(wdata)));                       // R5

endmodule

// File: rtl/uart_rb_rdmux.sv
`timescale 1ns/1ps
// Module: uart_rb_rdmux
// Selects the read byte for the addressed register. Returns zero when no
// read is in progress. Combinational; neighbour bytes are taken as presented.
module uart_rb_rdmux
    import uart_rb_pkg::*;
(
    input  logic              rd_en,
    input  tgt_e              tgt,
    input  logic [BYTE_W-1:0] rxd_byte,
    input  logic [BYTE_W-1:0] iid_byte,
    input  logic [BYTE_W-1:0] lstat_byte,
    input  logic [BYTE_W-1:0] mstat_byte,
    input  logic [BYTE_W-1:0] ien_byte,
    input  logic [BYTE_W-1:0] lctl_byte,
    input  logic [BYTE_W-1:0] mctl_byte,
    input  logic [BYTE_W-1:0] scrat_byte,
    input  logic [DIV_W-1:0]  div_word,
    output logic [BYTE_W-1:0] rdata
);

    // Route the addressed source onto the read bus.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (tgt)
                TGT_TXRX:  rdata = rxd_byte;
                TGT_DLO:   rdata = div_word[BYTE_W-1:0];
                TGT_DHI:   rdata = div_word[DIV_W-1:BYTE_W];
                TGT_IEN:   rdata = ien_byte;
                TGT_IDFC:  rdata = iid_byte;
                TGT_LCTL:  rdata = lctl_byte;
                TGT_MCTL:  rdata = mctl_byte;
                TGT_LSTAT: rdata = lstat_byte;
                TGT_MSTAT: rdata = mstat_byte;
                TGT_SCRAT: rdata = scrat_byte;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_rb_baud.sv
`timescale 1ns/1ps
// Module: uart_rb_baud
// Baud enable generator. tick16 pulses once every max(divisor,1) cycles;
// bit_tick marks every OVERSAMPLE-th tick16. Both counters restart on a
// divisor write. Assumes OVERSAMPLE is a power of two greater than one.
module uart_rb_baud
    import uart_rb_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_q,
    input  logic             restart,
    output logic             tick16,
    output logic             bit_tick
);

    localparam int SUB_W = $clog2(OVERSAMPLE);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cnt_q;
    logic [SUB_W-1:0] sub_q;
    logic             at_end;
    logic             sub_last;

    // Clamp a zero divisor to one so the enable never stalls.
    always_comb begin
        div_eff  = (div_q == '0) ? DIV_W'(1) : div_q;
        at_end   = (cnt_q >= (div_eff - DIV_W'(1)));
        sub_last = (sub_q == SUB_W'(OVERSAMPLE - 1));
        tick16   = at_end;
        bit_tick = at_end && sub_last;
    end

    // Clock-cycle counter within one oversampling period.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart || at_end) cnt_q <= '0;
        else                     cnt_q <= cnt_q + DIV_W'(1);
    end

    // Oversampling-period counter within one bit time.
    always_ff @(posedge clk) begin
        if (!rst_n)       sub_q <= '0;
        else if (restart) sub_q <= '0;
        else if (at_end)  sub_q <= sub_last ? '0 : sub_q + SUB_W'(1);
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && (div_q > DIV_W'(1)) && !restart) |=> !tick16);    // R8
    AST_ZERO_DIV_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> tick16);                                   // R9
    AST_BIT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !restart) |=> !bit_tick);                       // R10

endmodule

// File: rtl/uart_regbank.sv
`timescale 1ns/1ps
// Module: uart_regbank
// Top of the banked UART register file. Wires the decoder, the register
// storage, the read multiplexer and the baud enable generator, and exposes
// neighbour strobes. Assumes rd_en/wr_en are single-cycle per access.
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int IER_BITS   = 4,
    parameter int RESET_DIV  = 1,
    parameter int OVERSAMPLE = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        thr_wr,
    output logic [7:0]  thr_data,
    input  logic [7:0]  rbr_data,
    output logic        rbr_rd,
    input  logic [7:0]  iir_data,
    output logic        iir_rd,
    output logic        fcr_wr,
    output logic [7:0]  fcr_data,
    input  logic [7:0]  lsr_data,
    output logic        lsr_rd,
    input  logic [7:0]  msr_data,
    output logic        msr_rd,
    output logic [7:0]  ier,
    output logic [7:0]  lcr,
    output logic [7:0]  mcr,
    output logic [15:0] divisor,
    output logic        tick16,
    output logic        bit_tick
);

    tgt_e                tgt;
    logic                wr_dlo, wr_dhi, wr_ien, wr_lctl, wr_mctl, wr_scrat;
    logic [IER_BITS-1:0] ien_q;
    logic [BYTE_W-1:0]   scrat_q;
    logic                div_load;

    uart_rb_decode u_decode (
        .addr     (addr),
        .bank     (lcr[BANK_BIT]),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .tgt      (tgt),
        .wr_txd   (thr_wr),
        .wr_dlo   (wr_dlo),
        .wr_dhi   (wr_dhi),
        .wr_ien   (wr_ien),
        .wr_fctl  (fcr_wr),
        .wr_lctl  (wr_lctl),
        .wr_mctl  (wr_mctl),
        .wr_scrat (wr_scrat),
        .rd_rxd   (rbr_rd),
        .rd_iid   (iir_rd),
        .rd_lstat (lsr_rd),
        .rd_mstat (msr_rd)
    );

    uart_rb_regs #(
        .IER_BITS  (IER_BITS),
        .RESET_DIV (RESET_DIV)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (wdata),
        .wr_dlo   (wr_dlo),
        .wr_dhi   (wr_dhi),
        .wr_ien   (wr_ien),
        .wr_lctl  (wr_lctl),
        .wr_mctl  (wr_mctl),
        .wr_scrat (wr_scrat),
        .ien_q    (ien_q),
        .lctl_q   (lcr),
        .mctl_q   (mcr),
        .scrat_q  (scrat_q),
        .div_q    (divisor),
        .div_load (div_load)
    );

    // Zero-extend the implemented interrupt enable bits to a byte.
    always_comb begin
        ier      = BYTE_W'(ien_q);
        thr_data = wdata;
        fcr_data = wdata;
    end

    uart_rb_rdmux u_rdmux (
        .rd_en      (rd_en),
        .tgt        (tgt),
        .rxd_byte   (rbr_data),
        .iid_byte   (iir_data),
        .lstat_byte (lsr_data),
        .mstat_byte (msr_data),
        .ien_byte   (ier),
        .lctl_byte  (lcr),
        .mctl_byte  (mcr),
        .scrat_byte (scrat_q),
        .div_word   (divisor),
        .rdata      (rdata)
    );

    uart_rb_baud #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_q    (divisor),
        .restart  (div_load),
        .tick16   (tick16),
        .bit_tick (bit_tick)
    );

    AST_BANK_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr[BANK_BIT] && (addr == 3'd0)) |-> (!thr_wr && !rbr_rd)); // R3
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |-> (!thr_wr && !fcr_wr && !rbr_rd && !iir_rd
                                && !lsr_rd && !msr_rd && (rdata == 8'h00))); // R11

endmodule

// File: tb/uart_regbank_bench.sv
`timescale 1ns/1ps
// Bench for uart_regbank: a register access table walked by one loop, then
// directed checks for reset, strobes, banking and tick periods.
module uart_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        thr_wr, rbr_rd, iir_rd, fcr_wr, lsr_rd, msr_rd;
    logic [7:0]  thr_data, fcr_data, ier, lcr, mcr;
    logic [15:0] divisor;
    logic        tick16, bit_tick;

    localparam logic [7:0] RXB = 8'hA5, IIB = 8'hC1, LSB = 8'h60, MSB = 8'hB0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    uart_regbank u_uart_regbank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .thr_wr(thr_wr), .thr_data(thr_data),
        .rbr_data(RXB), .rbr_rd(rbr_rd), .iir_data(IIB), .iir_rd(iir_rd),
        .fcr_wr(fcr_wr), .fcr_data(fcr_data), .lsr_data(LSB), .lsr_rd(lsr_rd),
        .msr_data(MSB), .msr_rd(msr_rd), .ier(ier), .lcr(lcr), .mcr(mcr),
        .divisor(divisor), .tick16(tick16), .bit_tick(bit_tick)
    );

    // Vector: {write, offset[2:0], data[7:0], requirement[3:0]}; for reads
    // data is the expected byte.
    localparam int NV = 35;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {1'b0, 3'd3, 8'h00, 4'd1},   // R1 line control reset
        {1'b0, 3'd1, 8'h00, 4'd1},   // R1 interrupt enable reset
        {1'b0, 3'd4, 8'h00, 4'd1},   // R1 modem control reset
        {1'b0, 3'd7, 8'h00, 4'd1},   // R1 scratch reset
        {1'b1, 3'd7, 8'h5A, 4'd7},   // R7 scratch write
        {1'b0, 3'd7, 8'h5A, 4'd7},
        {1'b1, 3'd1, 8'hFF, 4'd4},   // R4 upper bits dropped
        {1'b0, 3'd1, 8'h0F, 4'd4},
        {1'b1, 3'd4, 8'h13, 4'd7},   // R7 modem control
        {1'b0, 3'd4, 8'h13, 4'd7},
        {1'b1, 3'd3, 8'h83, 4'd5},   // R5 bank bit set
        {1'b0, 3'd3, 8'h83, 4'd5},
        {1'b0, 3'd0, 8'h01, 4'd1},   // R1 divisor low reset
        {1'b0, 3'd1, 8'h00, 4'd1},   // R1 divisor high reset
        {1'b1, 3'd0, 8'h0C, 4'd3},   // R3 divisor low
        {1'b1, 3'd1, 8'h00, 4'd3},   // R3 divisor high
        {1'b0, 3'd0, 8'h0C, 4'd3},
        {1'b0, 3'd1, 8'h00, 4'd3},
        {1'b1, 3'd3, 8'h03, 4'd5},   // R5 bank bit clear
        {1'b0, 3'd3, 8'h03, 4'd5},
        {1'b0, 3'd1, 8'h0F, 4'd4},   // R4 enable kept across banking
        {1'b0, 3'd0, RXB,   4'd2},   // R2 receive byte
        {1'b0, 3'd2, IIB,   4'd6},   // R6 identification byte
        {1'b0, 3'd5, LSB,   4'd7},   // R7 line status
        {1'b0, 3'd6, MSB,   4'd7},   // R7 modem status
        {1'b1, 3'd5, 8'hFF, 4'd7},   // R7 write to status ignored
        {1'b0, 3'd5, LSB,   4'd7},
        {1'b1, 3'd3, 8'h80, 4'd5},
        {1'b1, 3'd1, 8'h55, 4'd3},   // R3 high byte while banked
        {1'b1, 3'd3, 8'h03, 4'd5},
        {1'b0, 3'd1, 8'h0F, 4'd4},   // R4 untouched by banked write
        {1'b1, 3'd3, 8'h80, 4'd5},
        {1'b0, 3'd1, 8'h55, 4'd3},
        {1'b1, 3'd1, 8'h00, 4'd3},
        {1'b1, 3'd3, 8'h03, 4'd5}
    };

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // Drive one access and leave it on the bus for sampling by the caller.
    task automatic hold(input logic w, input logic r,
                        input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = w; rd_en = r;
        #1;
    endtask

    task automatic idle();
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] dv);
        wr_reg(3'd3, 8'h80);
        wr_reg(3'd0, dv[7:0]);
        wr_reg(3'd1, dv[15:8]);
        wr_reg(3'd3, 8'h03);
    endtask

    // Cycles between two consecutive pulses of the selected enable.
    task automatic gap(input bit use_bit, output int n);
        do @(negedge clk); while (!(use_bit ? bit_tick : tick16));
        n = 0;
        do begin @(negedge clk); n++; end while (!(use_bit ? bit_tick : tick16));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state at the ports
        #1;
        chk(1, "divisor after reset", divisor, 16'h0001);
        chk(1, "lcr after reset", lcr, 8'h00);
        chk(1, "ier after reset", ier, 8'h00);
        chk(1, "mcr after reset", mcr, 8'h00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(8, "tick16 every cycle at divisor 1", tick16, 1'b1);
        end

        // Table walk
        for (int i = 0; i < NV; i++) begin
            automatic logic [15:0] v = VEC[i];
            if (v[15]) wr_reg(v[14:12], v[11:4]);
            else begin
                rd_reg(v[14:12], rb);
                chk(int'(v[3:0]), $sformatf("read offset %0d (vector %0d)", v[14:12], i),
                    rb, v[11:4]);
            end
        end
        chk(3, "divisor port", divisor, 16'h000C);

        // R2 transmit strobe and data
        hold(1'b1, 1'b0, 3'd0, 8'h3C);
        chk(2, "thr_wr on offset 0 write", thr_wr, 1'b1);
        chk(2, "thr_data", thr_data, 8'h3C);
        idle();
        hold(1'b0, 1'b1, 3'd0, 8'h00);
        chk(2, "rbr_rd on offset 0 read", rbr_rd, 1'b1);
        idle();

        // R6 offset 2 write and read strobes
        hold(1'b1, 1'b0, 3'd2, 8'hC7);
        chk(6, "fcr_wr", fcr_wr, 1'b1);
        chk(6, "fcr_data", fcr_data, 8'hC7);
        idle();
        chk(6, "lcr unchanged by fifo write", lcr, 8'h03);
        hold(1'b0, 1'b1, 3'd2, 8'h00);
        chk(6, "iir_rd", iir_rd, 1'b1);
        idle();

        // R7 status read strobes
        hold(1'b0, 1'b1, 3'd5, 8'h00);
        chk(7, "lsr_rd", lsr_rd, 1'b1);
        idle();
        hold(1'b0, 1'b1, 3'd6, 8'h00);
        chk(7, "msr_rd", msr_rd, 1'b1);
        idle();

        // R3 banked offset 0 raises no data strobes
        wr_reg(3'd3, 8'h80);
        hold(1'b1, 1'b1, 3'd0, 8'h0C);
        chk(3, "thr_wr blocked in divisor bank", thr_wr, 1'b0);
        chk(3, "rbr_rd blocked in divisor bank", rbr_rd, 1'b0);
        idle();
        wr_reg(3'd3, 8'h03);

        // R11 idle bus
        hold(1'b0, 1'b0, 3'd0, 8'hFF);
        chk(11, "no strobes while idle",
            {thr_wr, rbr_rd, iir_rd, fcr_wr, lsr_rd, msr_rd}, 6'b0);
        chk(11, "rdata zero while idle", rdata, 8'h00);
        idle();

        // R8 / R10 periods at divisor 12
        gap(1'b0, n);
        chk(8, "tick16 period at divisor 12", n, 12);
        gap(1'b1, n);
        chk(10, "bit_tick period at divisor 12", n, 192);

        // R9 zero divisor
        set_div(16'h0000);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(9, "tick16 every cycle at divisor 0", tick16, 1'b1);
        end

        // R8 / R10 at divisor 3
        set_div(16'h0003);
        gap(1'b0, n);
        chk(8, "tick16 period at divisor 3", n, 3);
        gap(1'b1, n);
        chk(10, "bit_tick period at divisor 3", n, 48);
        chk(10, "tick16 coincident with bit_tick", tick16, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule